// File: doc/BRIEF.md
# Two-Tier Prioritised Round-Robin Bus Arbiter

This block decides which port of a multi-module switch may place its next frame on a shared backplane bus. Ports sit in groups of equal size, one group per line module. Each group has its own local arbiter, and a central arbiter chooses among the groups. Each port with a frame ready asks for the bus at one of three urgency levels. Software chooses between the two lower levels with a per-port flag. The top level is forced on by the port's own input buffer when that buffer is close to full.

The central arbiter serves the most urgent level that any group reports. Among the groups that have a request at that level, it picks one in rotating order. The local arbiter of the chosen group then picks one of its ports in rotating order, again only among ports requesting at that level. A local arbiter never grants a port on its own; it acts only when the central arbiter has chosen its group.

The grant covers one frame. It is held until the granted port signals end of frame, or until a destination answers with retry. After a retry the source gives up the attempt and simply asks again later. One idle cycle always separates two grants.

Top module: `hier_bus_arb`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `gnt` is all zero and `bus_busy` is low.
- R2: At most one bit of `gnt` is ever set, and `bus_busy` is high exactly when one bit is set.
- R3: A requesting port's level is 2 (buffer-urgent) when `buf_occ`·10 > `BUF_CAP`·9. Otherwise it is 1 when its `req_hi` bit is set, and 0 when it is not. A new grant always goes to a port at the highest level among all requesting ports, and `gnt_lvl` reports that level while the grant lasts.
- R4: Port index p sits in module p / `PORTS_PER_MOD`. At the serviced level, the module chosen is the first candidate module found when searching upward, with wrap-around, from the module granted last at that same level. Module 0 is searched first after reset. A separate pointer is kept for each level.
- R5: Within the chosen module, the port chosen is the first port requesting at the serviced level, found when searching upward with wrap-around from the port that module granted last at that level. Local port 0 is searched first after reset. Each module keeps its own pointer for each level.
- R6: Once a port holds the grant, `gnt` and `gnt_lvl` stay unchanged until the granted port's `eof` bit or `retry` is high. `eof` bits of other ports have no effect.
- R7: When the holder's `eof` or `retry` is high in a cycle, `gnt` is zero and `bus_busy` is low in the next cycle. A grant appears in the cycle after any idle cycle in which some `req_valid` bit is high.
- R8: `retry` releases the current grant in the same way as end of frame. `retry` while the bus is idle has no effect.
- R9: A port whose `req_valid` bit is low is never granted, whatever its buffer occupancy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| req_valid | input | NUM_MODS·PORTS_PER_MOD | Per-port frame-ready request |
| req_hi | input | NUM_MODS·PORTS_PER_MOD | Per-port software level select (1 = level 1) |
| buf_occ | input | NUM_MODS·PORTS_PER_MOD·OCC_W | Per-port input buffer occupancy, port p at bits p·OCC_W upward |
| eof | input | NUM_MODS·PORTS_PER_MOD | Per-port end-of-frame strobe |
| retry | input | 1 | Destination has no room, abandon the current transfer |
| gnt | output | NUM_MODS·PORTS_PER_MOD | One-hot port grant |
| gnt_lvl | output | 2 | Level being serviced by the current grant |
| bus_busy | output | 1 | A grant is active |

## Verification
Every port asking at level 0 with immediate end of frame shows whether both rotations walk modules and ports in the stated order. Mixed levels with occupancy set at 180 and 181 against a capacity of 200 separate the urgent threshold from the software level and show whether level pointers are kept apart. `eof` pulses on ports other than the holder, `retry` on a busy bus and on an idle one, and idle ports with full buffers show whether a grant ends only for the right reason. A long random run with skewed levels then compares every cycle against a reference model.

// File: rtl/hba_pkg.sv
package hba_pkg;
  typedef enum logic [1:0] {
    LVL_NORM = 2'd0,
    LVL_HIGH = 2'd1,
    LVL_URG  = 2'd2
  } lvl_e;

  function automatic int lvl_idx(lvl_e l);
    case (l)
      LVL_URG:  lvl_idx = 2;
      LVL_HIGH: lvl_idx = 1;
      default:  lvl_idx = 0;
    endcase
  endfunction
endpackage

// File: rtl/hba_rr_pick.sv
module hba_rr_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] last,
  output logic          hit,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  onehot
);
  always_comb begin
    hit = 1'b0;
    idx = last;
    for (int k = 1; k <= N; k++) begin
      int c;
      c = int'(last) + k;
      if (c >= N) c = c - N;
      if (!hit && req[c]) begin
        hit = 1'b1;
        idx = IW'(c);
      end
    end
    onehot = '0;
    if (hit) onehot[idx] = 1'b1;
  end
endmodule

// File: rtl/hba_slave.sv
module hba_slave
  import hba_pkg::*;
#(
  parameter int PP      = 4,
  parameter int OCC_W   = 8,
  parameter int BUF_CAP = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PP-1:0]     req_valid,
  input  logic [PP-1:0]     req_hi,
  input  logic [PP*OCC_W-1:0] buf_occ,
  input  logic              mod_gnt,
  input  logic              load,
  input  lvl_e              srv_lvl,
  output logic              mod_req,
  output lvl_e              mod_lvl,
  output logic [PP-1:0]     port_sel
);
  localparam int IW = (PP > 1) ? $clog2(PP) : 1;
  localparam int unsigned LIMIT = (BUF_CAP * 9) / 10;
  localparam logic [OCC_W-1:0] LIM_V = OCC_W'(LIMIT);

  lvl_e          plvl [PP];
  logic [PP-1:0] at_lvl [3];
  logic [PP-1:0] cur_req;
  logic [IW-1:0] ptr_q [3];
  logic [IW-1:0] ptr_d [3];
  logic          hit;
  logic [IW-1:0] pick;
  logic [PP-1:0] pick_oh;
  int            sidx;

  for (genvar p = 0; p < PP; p++) begin : g_port
    logic [OCC_W-1:0] occ_p;
    logic             urg;
    assign occ_p   = buf_occ[p*OCC_W +: OCC_W];
    assign urg     = occ_p > LIM_V;
    assign plvl[p] = urg ? LVL_URG : (req_hi[p] ? LVL_HIGH : LVL_NORM);
  end

  always_comb begin
    for (int l = 0; l < 3; l++) at_lvl[l] = '0;
    for (int p = 0; p < PP; p++) begin
      if (req_valid[p]) at_lvl[lvl_idx(plvl[p])][p] = 1'b1;
    end
    mod_req = |req_valid;
    if (|at_lvl[2])      mod_lvl = LVL_URG;
    else if (|at_lvl[1]) mod_lvl = LVL_HIGH;
    else                 mod_lvl = LVL_NORM;
    sidx    = lvl_idx(srv_lvl);
    cur_req = at_lvl[sidx];
  end

  hba_rr_pick #(.N(PP), .IW(IW)) u_pick (
    .req    (cur_req),
    .last   (ptr_q[sidx]),
    .hit    (hit),
    .idx    (pick),
    .onehot (pick_oh)
  );

  assign port_sel = mod_gnt ? pick_oh : '0;

  always_comb begin
    ptr_d = ptr_q;
    if (load && mod_gnt && hit) ptr_d[sidx] = pick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < 3; l++) ptr_q[l] <= IW'(PP - 1);
    end else if (load && mod_gnt) begin
      ptr_q <= ptr_d;
    end
  end
endmodule

// File: rtl/hba_master.sv
module hba_master
  import hba_pkg::*;
#(
  parameter int NM = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NM-1:0]   mod_req,
  input  logic [NM*2-1:0] mod_lvl_flat,
  input  logic            load,
  output lvl_e            srv_lvl,
  output logic            any_req,
  output logic [NM-1:0]   mod_gnt
);
  localparam int IW = (NM > 1) ? $clog2(NM) : 1;

  logic [NM-1:0] at_lvl [3];
  logic [NM-1:0] cand;
  logic [IW-1:0] ptr_q [3];
  logic [IW-1:0] ptr_d [3];
  logic          hit;
  logic [IW-1:0] pick;
  int            sidx;

  always_comb begin
    for (int l = 0; l < 3; l++) at_lvl[l] = '0;
    for (int m = 0; m < NM; m++) begin
      if (mod_req[m]) at_lvl[lvl_idx(lvl_e'(mod_lvl_flat[2*m +: 2]))][m] = 1'b1;
    end
    any_req = |mod_req;
    if (|at_lvl[2])      srv_lvl = LVL_URG;
    else if (|at_lvl[1]) srv_lvl = LVL_HIGH;
    else                 srv_lvl = LVL_NORM;
    sidx = lvl_idx(srv_lvl);
    cand = at_lvl[sidx];
  end

  hba_rr_pick #(.N(NM), .IW(IW)) u_pick (
    .req    (cand),
    .last   (ptr_q[sidx]),
    .hit    (hit),
    .idx    (pick),
    .onehot (mod_gnt)
  );

  always_comb begin
    ptr_d = ptr_q;
    if (load && hit) ptr_d[sidx] = pick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < 3; l++) ptr_q[l] <= IW'(NM - 1);
    end else if (load) begin
      ptr_q <= ptr_d;
    end
  end
endmodule

// File: rtl/hier_bus_arb.sv
module hier_bus_arb
  import hba_pkg::*;
#(
  parameter int NUM_MODS      = 4,
  parameter int PORTS_PER_MOD = 4,
  parameter int OCC_W         = 8,
  parameter int BUF_CAP       = 200
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic [NUM_MODS*PORTS_PER_MOD-1:0]       req_valid,
  input  logic [NUM_MODS*PORTS_PER_MOD-1:0]       req_hi,
  input  logic [NUM_MODS*PORTS_PER_MOD*OCC_W-1:0] buf_occ,
  input  logic [NUM_MODS*PORTS_PER_MOD-1:0]       eof,
  input  logic                                    retry,
  output logic [NUM_MODS*PORTS_PER_MOD-1:0]       gnt,
  output logic [1:0]                              gnt_lvl,
  output logic                                    bus_busy
);
  localparam int NP = NUM_MODS * PORTS_PER_MOD;
  localparam int PW = PORTS_PER_MOD * OCC_W;

  logic [NUM_MODS-1:0]   mod_req;
  logic [NUM_MODS*2-1:0] mod_lvl_flat;
  logic [NUM_MODS-1:0]   mod_gnt;
  logic [NP-1:0]         sel_all;
  lvl_e                  srv_lvl;
  logic                  any_req;
  logic                  load;
  logic                  done;

  logic [NP-1:0] gnt_q, gnt_d;
  logic [1:0]    lvl_q, lvl_d;
  logic          busy_q, busy_d;

  hba_master #(.NM(NUM_MODS)) u_master (
    .clk          (clk),
    .rst_n        (rst_n),
    .mod_req      (mod_req),
    .mod_lvl_flat (mod_lvl_flat),
    .load         (load),
    .srv_lvl      (srv_lvl),
    .any_req      (any_req),
    .mod_gnt      (mod_gnt)
  );

  for (genvar m = 0; m < NUM_MODS; m++) begin : g_mod
    lvl_e lvl_m;
    hba_slave #(.PP(PORTS_PER_MOD), .OCC_W(OCC_W), .BUF_CAP(BUF_CAP)) u_slave (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid[m*PORTS_PER_MOD +: PORTS_PER_MOD]),
      .req_hi    (req_hi[m*PORTS_PER_MOD +: PORTS_PER_MOD]),
      .buf_occ   (buf_occ[m*PW +: PW]),
      .mod_gnt   (mod_gnt[m]),
      .load      (load),
      .srv_lvl   (srv_lvl),
      .mod_req   (mod_req[m]),
      .mod_lvl   (lvl_m),
      .port_sel  (sel_all[m*PORTS_PER_MOD +: PORTS_PER_MOD])
    );
    assign mod_lvl_flat[2*m +: 2] = lvl_m;
  end

  assign load = !busy_q && any_req;
  assign done = busy_q && ((|(gnt_q & eof)) || retry);

  always_comb begin
    gnt_d  = gnt_q;
    lvl_d  = lvl_q;
    busy_d = busy_q;
    if (load) begin
      gnt_d  = sel_all;
      lvl_d  = srv_lvl;
      busy_d = 1'b1;
    end else if (done) begin
      gnt_d  = '0;
      busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_q  <= '0;
      lvl_q  <= 2'd0;
      busy_q <= 1'b0;
    end else if (load || done) begin
      gnt_q  <= gnt_d;
      lvl_q  <= lvl_d;
      busy_q <= busy_d;
    end
  end

  assign gnt      = gnt_q;
  assign gnt_lvl  = lvl_q;
  assign bus_busy = busy_q;
endmodule

// File: rtl/hba_chk.sv
module hba_chk #(
  parameter int NP = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NP-1:0] req_valid,
  input logic [NP-1:0] eof,
  input logic          retry,
  input logic [NP-1:0] gnt,
  input logic [1:0]    gnt_lvl,
  input logic          bus_busy
);
  logic ends;
  assign ends = bus_busy && ((|(gnt & eof)) || retry);

  // R2
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt) && (bus_busy == (gnt != '0)));

  // R6
  gnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_busy && !ends) |=> (bus_busy && $stable(gnt) && $stable(gnt_lvl)));

  // R7
  idle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ends |=> (!bus_busy && gnt == '0));

  // R9
  gnt_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_busy) |-> ((gnt & ~$past(req_valid)) == '0));

  // R8
  idle_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_busy && retry && req_valid == '0) |=> !bus_busy);
endmodule

bind hier_bus_arb hba_chk #(.NP(NUM_MODS*PORTS_PER_MOD)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .eof       (eof),
  .retry     (retry),
  .gnt       (gnt),
  .gnt_lvl   (gnt_lvl),
  .bus_busy  (bus_busy)
);

// File: tb/hier_bus_arb_tb_top.sv
module hier_bus_arb_tb_top;
  localparam int NM  = 4;
  localparam int PP  = 4;
  localparam int N   = NM * PP;
  localparam int OW  = 8;
  localparam int CAP = 200;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic            rst_n;
  logic [N-1:0]    req_valid, req_hi, eof;
  logic [N*OW-1:0] buf_occ;
  logic            retry;
  logic [N-1:0]    gnt;
  logic [1:0]      gnt_lvl;
  logic            bus_busy;

  int checks = 0;
  int errors = 0;

  int m_ptr [3];
  int s_ptr [NM][3];
  bit e_busy;
  int e_idx;
  int e_lvl;

  hier_bus_arb #(.NUM_MODS(NM), .PORTS_PER_MOD(PP), .OCC_W(OW), .BUF_CAP(CAP)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_hi(req_hi),
    .buf_occ(buf_occ), .eof(eof), .retry(retry),
    .gnt(gnt), .gnt_lvl(gnt_lvl), .bus_busy(bus_busy)
  );

  function automatic int port_lvl(int p);
    int occ;
    if (!req_valid[p]) return -1;
    occ = int'(buf_occ[p*OW +: OW]);
    if (occ * 10 > CAP * 9) return 2;
    return req_hi[p] ? 1 : 0;
  endfunction

  task automatic chk(string tag, string what, bit ok, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model_next();
    int srv;
    int mod_sel;
    int prt_sel;
    if (e_busy) begin
      if (eof[e_idx] || retry) e_busy = 1'b0;
    end else begin
      srv = -1;
      for (int p = 0; p < N; p++) if (port_lvl(p) > srv) srv = port_lvl(p);
      if (srv >= 0) begin
        mod_sel = -1;
        for (int k = 1; k <= NM; k++) begin
          int m;
          bit has;
          m = (m_ptr[srv] + k) % NM;
          has = 1'b0;
          for (int q = 0; q < PP; q++) if (port_lvl(m*PP + q) == srv) has = 1'b1;
          if (mod_sel < 0 && has) mod_sel = m;
        end
        prt_sel = -1;
        for (int k = 1; k <= PP; k++) begin
          int q;
          q = (s_ptr[mod_sel][srv] + k) % PP;
          if (prt_sel < 0 && port_lvl(mod_sel*PP + q) == srv) prt_sel = q;
        end
        m_ptr[srv] = mod_sel;
        s_ptr[mod_sel][srv] = prt_sel;
        e_busy = 1'b1;
        e_idx  = mod_sel*PP + prt_sel;
        e_lvl  = srv;
      end
    end
  endtask

  task automatic step(string tag);
    logic [N-1:0] exp_g;
    model_next();
    @(posedge clk);
    @(negedge clk);
    exp_g = e_busy ? (N'(1) << e_idx) : '0;
    chk(tag, "bus_busy", bus_busy == e_busy, int'(bus_busy), int'(e_busy));
    chk(tag, "gnt", gnt == exp_g, int'(gnt), int'(exp_g));
    chk("R2", "grant count", $countones(gnt) <= 1, $countones(gnt), 1);
    if (e_busy) chk("R3", "gnt_lvl", int'(gnt_lvl) == e_lvl, int'(gnt_lvl), e_lvl);
  endtask

  task automatic set_occ(int p, int v);
    buf_occ[p*OW +: OW] = OW'(v);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int l = 0; l < 3; l++) begin
      m_ptr[l] = NM - 1;
      for (int m = 0; m < NM; m++) s_ptr[m][l] = PP - 1;
    end
    e_busy = 1'b0; e_idx = 0; e_lvl = 0;
    rst_n = 1'b0; req_valid = '0; req_hi = '0; eof = '0; retry = 1'b0; buf_occ = '0;
    repeat (3) @(negedge clk);
    // R1: in reset
    chk("R1", "gnt in reset", gnt == '0, int'(gnt), 0);
    chk("R1", "busy in reset", !bus_busy, int'(bus_busy), 0);
    rst_n = 1'b1;
    step("R1");

    // R9: full buffers but no requests
    for (int p = 0; p < N; p++) set_occ(p, 255);
    step("R9"); step("R9");
    for (int p = 0; p < N; p++) set_occ(p, 0);

    // R3: occupancy 180 is not urgent, software high wins
    req_valid = '0; req_valid[0] = 1'b1; req_valid[5] = 1'b1;
    req_hi[5] = 1'b1; set_occ(0, 180);
    step("R3");
    chk("R3", "high beats 180", gnt[5] == 1'b1, int'(gnt), 32);
    eof = '1; step("R3"); eof = '0;
    // R3: occupancy 181 becomes urgent
    set_occ(0, 181);
    step("R3");
    chk("R3", "181 is urgent", gnt[0] == 1'b1 && gnt_lvl == 2'd2, int'(gnt), 1);
    set_occ(0, 0); req_hi = '0;

    // R6: eof on other ports ignored
    req_valid = '1;
    eof = '1; step("R6");
    for (int i = 0; i < 3; i++) begin
      eof = ~(N'(1) << e_idx);
      step("R6");
    end
    eof = N'(1) << e_idx; step("R7"); eof = '0;

    // R8: retry releases; retry while idle ignored
    step("R8");
    retry = 1'b1; step("R8"); retry = 1'b0;
    req_valid = '0; step("R8");
    retry = 1'b1; step("R8"); step("R8"); retry = 1'b0;

    // R4: all ports at level 0, immediate end of frame
    req_valid = '1; eof = '1;
    for (int i = 0; i < 40; i++) step("R4");

    // R5: single module with mixed levels, separate level pointers
    req_valid = '0; req_valid[PP +: PP] = '1; req_hi[PP +: 2] = 2'b11;
    for (int i = 0; i < 8; i++) step("R5");
    req_hi[PP +: 2] = 2'b00;
    for (int i = 0; i < 8; i++) step("R5");
    req_hi = '0;

    // R7 and mix: random traffic
    for (int i = 0; i < 4000; i++) begin
      for (int p = 0; p < N; p++) begin
        req_valid[p] = ($urandom_range(0, 99) < 55);
        req_hi[p]    = ($urandom_range(0, 99) < 30);
        eof[p]       = ($urandom_range(0, 99) < 30);
        set_occ(p, ($urandom_range(0, 99) < 12) ? int'($urandom_range(176, 255))
                                                : int'($urandom_range(0, 175)));
      end
      retry = ($urandom_range(0, 99) < 6);
      step("R7");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule